// File: doc/BRIEF.md
# Two-by-two bit-steered packet router

This block is one element of a time-ordering network for 34-bit hit packets. Two inputs each offer at most one packet per cycle. The element reads a single bit of the packet's 9-bit bunch-crossing identifier and uses it to send the packet to one of two outputs. That bit is picked by parameters, counted either from the least or from the most significant end of the identifier. Each input keeps one FIFO for each destination, which gives four FIFOs in all. Each output drains the two FIFOs that hold packets bound for it.

Each output takes from whichever of its two candidate FIFOs holds more words, so the deeper backlog drains first. The chosen word passes through a two-to-one multiplexer into an output register. The element never pushes back on its inputs. A packet that meets a full FIFO is discarded, and a one-cycle drop pulse is raised for that FIFO. A full flag for each FIFO shows when it is saturated. Several elements of this kind can be chained, each steering on a different identifier bit, to group packets by identifier.

Top module: `bit_steer_router_2x2`

## Requirements
- R1: A packet is 34 bits with these fields: hit pattern in bits [7:0], identifier in bits [16:8], superpixel address in bits [29:17] and chip number in bits [33:30]. The steering bit is packet bit 8+STEER_OFS when STEER_FROM_MSB=0.
- R2: A packet whose steering bit is v leaves on output v only. The other output does not show it.
- R3: A packet accepted in cycle c by an idle element is valid on its output in cycle c+2, bit-for-bit unchanged. No output is valid in cycle c+1.
- R4: When both candidate FIFOs of an output hold words, the output takes from the one that holds more words.
- R5: When the two candidate FIFOs hold equal non-zero counts, the FIFO of input 0 wins. An empty FIFO is never selected, and an output whose two FIFOs are both empty is invalid.
- R6: Packets taken from one FIFO leave in the order they arrived.
- R7: Packets that arrive on both inputs in the same cycle for the same destination are both accepted. Neither input stalls the other.
- R8: FIFO f raises full_o[f] while it holds FIFO_DEPTH words. The index is f = 2*input + destination.
- R9: A packet that meets a full FIFO is discarded, even if that FIFO is read in the same cycle. The FIFO's drop_o bit is high for exactly the following cycle, once for each discarded packet.
- R10: While reset is asserted and right after it, no output is valid and every full and drop bit is 0.
- R11: With STEER_FROM_MSB=1 the steering bit is packet bit 16-STEER_OFS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in0_valid_i | input | 1 | Input 0 packet present |
| in0_pkt_i | input | 34 | Input 0 packet |
| in1_valid_i | input | 1 | Input 1 packet present |
| in1_pkt_i | input | 34 | Input 1 packet |
| out0_valid_o | output | 1 | Output 0 packet valid (registered) |
| out0_pkt_o | output | 34 | Output 0 packet (registered) |
| out1_valid_o | output | 1 | Output 1 packet valid (registered) |
| out1_pkt_o | output | 34 | Output 1 packet (registered) |
| full_o | output | 4 | Per-FIFO full flag, index 2*input+destination |
| drop_o | output | 4 | Per-FIFO one-cycle drop pulse |

## Verification
On every cycle the assertions check four things. Each output carries only packets whose steering bit matches that output. A drop pulse follows only a write attempt into a FIFO that was full. A full flag rises only after a write into that FIFO. The selection order between the two candidate FIFOs, the latency, the data integrity, and the exact drop and delivery counts under saturation can only be shown by the bench's scenarios. These are a sweep over every identifier value on both inputs, two contention patterns with hand-derived output sequences, and a saturating burst on a four-word FIFO.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;
  localparam int PKT_W    = 34;
  localparam int HIT_W    = 8;
  localparam int BCID_W   = 9;
  localparam int SPX_W    = 13;
  localparam int CHIP_W   = 4;
  localparam int BCID_LSB = HIT_W;

  typedef logic [PKT_W-1:0] pkt_t;

  // packet bit index of the steering bit
  function automatic int steer_pos(input bit from_msb, input int ofs);
    return BCID_LSB + (from_msb ? (BCID_W - 1 - ofs) : ofs);
  endfunction
endpackage

// File: rtl/rtr_fifo.sv
module rtr_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 512,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  data_i,
  input  logic          rd_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          drop_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          drop_q;
  logic          full, wr_ok, rd_ok;

  assign full  = (count_q == CW'(DEPTH));
  assign wr_ok = wr_i && !full;            // full check ignores same-cycle read
  assign rd_ok = rd_i && (count_q != '0);

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      drop_q   <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (rd_ok) rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      count_q <= count_q + CW'(wr_ok) - CW'(rd_ok);
      drop_q  <= wr_i && full;
    end
  end

  assign data_o  = mem[rd_ptr_q];
  assign count_o = count_q;
  assign full_o  = full;
  assign drop_o  = drop_q;
endmodule

// File: rtl/rtr_out_port.sv
module rtr_out_port #(
  parameter int W  = 34,
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_a_i,
  input  logic [W-1:0]  pkt_a_i,
  input  logic [CW-1:0] cnt_b_i,
  input  logic [W-1:0]  pkt_b_i,
  output logic          pop_a_o,
  output logic          pop_b_o,
  output logic          valid_o,
  output logic [W-1:0]  pkt_o
);
  logic         pick_b, pop_a, pop_b;
  logic         valid_q;
  logic [W-1:0] pkt_q;

  // source b only when strictly fuller; ties go to source a
  assign pick_b = (cnt_b_i > cnt_a_i);
  assign pop_b  = pick_b;
  assign pop_a  = !pick_b && (cnt_a_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pkt_q   <= '0;
    end else begin
      valid_q <= pop_a || pop_b;
      if (pop_a || pop_b) pkt_q <= pick_b ? pkt_b_i : pkt_a_i;
    end
  end

  assign pop_a_o = pop_a;
  assign pop_b_o = pop_b;
  assign valid_o = valid_q;
  assign pkt_o   = pkt_q;
endmodule

// File: rtl/bit_steer_router_2x2.sv
module bit_steer_router_2x2
  import pkt_router_pkg::*;
#(
  parameter int FIFO_DEPTH     = 512,
  parameter bit STEER_FROM_MSB = 1'b0,
  parameter int STEER_OFS      = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in0_valid_i,
  input  logic [PKT_W-1:0] in0_pkt_i,
  input  logic             in1_valid_i,
  input  logic [PKT_W-1:0] in1_pkt_i,
  output logic             out0_valid_o,
  output logic [PKT_W-1:0] out0_pkt_o,
  output logic             out1_valid_o,
  output logic [PKT_W-1:0] out1_pkt_o,
  output logic [3:0]       full_o,
  output logic [3:0]       drop_o
);
  localparam int STEER_POS = steer_pos(STEER_FROM_MSB, STEER_OFS);
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);
  localparam int N_IN      = 2;
  localparam int N_OUT     = 2;
  localparam int N_FIFO    = N_IN * N_OUT;

  logic [N_IN-1:0]   in_vld;
  pkt_t              in_pkt   [N_IN];
  logic [N_FIFO-1:0] wr_en, rd_en;
  pkt_t              fifo_dout [N_FIFO];
  logic [CNT_W-1:0]  fifo_cnt  [N_FIFO];
  logic [N_OUT-1:0]  out_vld;
  pkt_t              out_pkt  [N_OUT];

  assign in_vld    = {in1_valid_i, in0_valid_i};
  assign in_pkt[0] = in0_pkt_i;
  assign in_pkt[1] = in1_pkt_i;

  // FIFO index = input*N_OUT + destination
  for (genvar i = 0; i < N_IN; i++) begin : g_steer
    assign wr_en[i*N_OUT + 0] = in_vld[i] && !in_pkt[i][STEER_POS];
    assign wr_en[i*N_OUT + 1] = in_vld[i] &&  in_pkt[i][STEER_POS];
  end

  for (genvar f = 0; f < N_FIFO; f++) begin : g_fifo
    rtr_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_en[f]),
      .data_i (in_pkt[f / N_OUT]),
      .rd_i   (rd_en[f]),
      .data_o (fifo_dout[f]),
      .count_o(fifo_cnt[f]),
      .full_o (full_o[f]),
      .drop_o (drop_o[f])
    );
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    rtr_out_port #(.W(PKT_W), .CW(CNT_W)) u_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_a_i(fifo_cnt[o]),
      .pkt_a_i(fifo_dout[o]),
      .cnt_b_i(fifo_cnt[N_OUT + o]),
      .pkt_b_i(fifo_dout[N_OUT + o]),
      .pop_a_o(rd_en[o]),
      .pop_b_o(rd_en[N_OUT + o]),
      .valid_o(out_vld[o]),
      .pkt_o  (out_pkt[o])
    );
  end

  assign out0_valid_o = out_vld[0];
  assign out0_pkt_o   = out_pkt[0];
  assign out1_valid_o = out_vld[1];
  assign out1_pkt_o   = out_pkt[1];
endmodule

// File: rtl/rtr_checker.sv
module rtr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in0_valid_i,
  input logic       in0_bit_i,
  input logic       in1_valid_i,
  input logic       in1_bit_i,
  input logic       out0_valid_o,
  input logic       out0_bit_o,
  input logic       out1_valid_o,
  input logic       out1_bit_o,
  input logic [3:0] full_o,
  input logic [3:0] drop_o
);
  logic [3:0] wr_try;
  assign wr_try = {in1_valid_i &&  in1_bit_i, in1_valid_i && !in1_bit_i,
                   in0_valid_i &&  in0_bit_i, in0_valid_i && !in0_bit_i};

  AST_OUT0_STEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out0_valid_o |-> !out0_bit_o); // R2
  AST_OUT1_STEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out1_valid_o |-> out1_bit_o); // R2

  for (genvar f = 0; f < 4; f++) begin : g_f
    AST_DROP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_o[f] |-> $past(wr_try[f] && full_o[f])); // R9
    AST_FULL_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(full_o[f]) |-> $past(wr_try[f])); // R8
  end
endmodule

bind bit_steer_router_2x2 rtr_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in0_valid_i (in0_valid_i),
  .in0_bit_i   (in0_pkt_i[STEER_POS]),
  .in1_valid_i (in1_valid_i),
  .in1_bit_i   (in1_pkt_i[STEER_POS]),
  .out0_valid_o(out0_valid_o),
  .out0_bit_o  (out0_pkt_o[STEER_POS]),
  .out1_valid_o(out1_valid_o),
  .out1_bit_o  (out1_pkt_o[STEER_POS]),
  .full_o      (full_o),
  .drop_o      (drop_o)
);

// File: tb/tb_bit_steer_router_2x2.sv
`timescale 1ns/1ps
module tb_bit_steer_router_2x2;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in0_v = 1'b0, in1_v = 1'b0;
  logic [33:0] in0_p = '0, in1_p = '0;
  logic        o0_v, o1_v, m0_v, m1_v;
  logic [33:0] o0_p, o1_p, m0_p, m1_p;
  logic [3:0]  full, drop, m_full, m_drop;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  // steering bit = identifier bit 1
  bit_steer_router_2x2 #(.FIFO_DEPTH(DEPTH), .STEER_FROM_MSB(1'b0), .STEER_OFS(1)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in0_valid_i(in0_v), .in0_pkt_i(in0_p), .in1_valid_i(in1_v), .in1_pkt_i(in1_p),
    .out0_valid_o(o0_v), .out0_pkt_o(o0_p), .out1_valid_o(o1_v), .out1_pkt_o(o1_p),
    .full_o(full), .drop_o(drop));

  // steering bit = identifier bit 8
  bit_steer_router_2x2 #(.FIFO_DEPTH(DEPTH), .STEER_FROM_MSB(1'b1), .STEER_OFS(0)) dut_m (
    .clk_i(clk), .rst_ni(rst_n),
    .in0_valid_i(in0_v), .in0_pkt_i(in0_p), .in1_valid_i(in1_v), .in1_pkt_i(in1_p),
    .out0_valid_o(m0_v), .out0_pkt_o(m0_p), .out1_valid_o(m1_v), .out1_pkt_o(m1_p),
    .full_o(m_full), .drop_o(m_drop));

  function automatic logic [33:0] mk(input logic [3:0] chip, input logic [12:0] spx,
                                     input logic [8:0] bc, input logic [7:0] hit);
    return {chip, spx, bc, hit};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    in0_v = 1'b0; in1_v = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [33:0] ea [6];
    logic [33:0] pk;
    int drops, outs;
    bit o1_seen;

    // R10 reset state
    repeat (3) @(negedge clk);
    check(!o0_v && !o1_v && full == 0 && drop == 0, "R10", "in reset",
          {o0_v, o1_v, full, drop}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!o0_v && !o1_v && full == 0 && drop == 0, "R10", "after reset",
          {o0_v, o1_v, full, drop}, 0);

    // R1 R2 R3 R11: every identifier on both inputs
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 512; b++) begin
        logic [8:0] bc;
        logic d, dm;
        bc = 9'(b);
        pk = mk(4'(b) ^ 4'(p), 13'(b * 13 + p), bc, 8'(b) ^ 8'h5a);
        d  = bc[1];
        dm = bc[8];
        if (p == 0) begin in0_v = 1'b1; in0_p = pk; end
        else        begin in1_v = 1'b1; in1_p = pk; end
        @(negedge clk);
        in0_v = 1'b0; in1_v = 1'b0;
        check(!o0_v && !o1_v && !m0_v && !m1_v, "R3", "not before c+2",
              {o0_v, o1_v, m0_v, m1_v}, 0);
        @(negedge clk);
        check((d ? o1_v : o0_v) && (d ? o1_p : o0_p) == pk, "R3", "lsb-mode data at c+2",
              d ? o1_p : o0_p, pk);
        check(!(d ? o0_v : o1_v), "R2", "lsb-mode other output silent", d ? o0_v : o1_v, 0);
        check((d ? o1_p[9] : o0_p[9]) == d, "R1", "steer bit position", d ? o1_p[9] : o0_p[9], d);
        check((dm ? m1_v : m0_v) && (dm ? m1_p : m0_p) == pk, "R11", "msb-mode output",
              dm ? m1_p : m0_p, pk);
        check(!(dm ? m0_v : m1_v), "R11", "msb-mode other output silent", dm ? m0_v : m1_v, 0);
      end
    end
    idle(4);

    // R4 R5 R6 R7: both inputs to destination 0 for three cycles
    for (int i = 0; i < 3; i++) begin
      ea[2*i]   = mk(4'd1, 13'(i), 9'd0, 8'(i));
      ea[2*i+1] = mk(4'd2, 13'(i), 9'd0, 8'(i));
    end
    for (int k = 0; k < 10; k++) begin
      if (k >= 2 && k <= 7)
        check(o0_v && o0_p == ea[k-2], "R4", "fuller-first sequence", o0_p, ea[k-2]);
      else
        check(!o0_v, "R5", "idle when both empty", o0_v, 0);
      check(!o1_v, "R7", "no leak to output 1", o1_v, 0);
      in0_v = (k < 3); in0_p = ea[2*((k < 3) ? k : 0)];
      in1_v = (k < 3); in1_p = ea[2*((k < 3) ? k : 0)+1];
      @(negedge clk);
    end
    idle(4);

    // R5 R6: input 0 wins ties, input 1 drains last
    ea[0] = mk(4'd3, 13'd0, 9'd2, 8'd0);
    ea[1] = mk(4'd3, 13'd1, 9'd2, 8'd1);
    ea[2] = mk(4'd3, 13'd2, 9'd2, 8'd2);
    ea[3] = mk(4'd4, 13'd9, 9'd2, 8'd9);
    for (int k = 0; k < 8; k++) begin
      if (k >= 2 && k <= 5)
        check(o1_v && o1_p == ea[k-2], "R5", "tie goes to input 0", o1_p, ea[k-2]);
      else
        check(!o1_v, "R6", "no extra packet", o1_v, 0);
      in0_v = (k < 3); in0_p = ea[(k < 3) ? k : 0];
      in1_v = (k == 0); in1_p = ea[3];
      @(negedge clk);
    end
    idle(4);

    // R8 R9: saturate destination 0 from both inputs for 10 cycles
    drops = 0; outs = 0; o1_seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (k == 6) check(full == 4'b0100, "R8", "full in cycle 6", full, 4'b0100);
      if (k == 7) begin
        check(drop == 4'b0100, "R9", "drop pulse cycle 7", drop, 4'b0100);
        check(full == 4'b0001, "R8", "full in cycle 7", full, 4'b0001);
      end
      if (k < 7) check(drop == 0, "R9", "no early drop", drop, 0);
      drops += $countones(drop);
      if (o0_v) outs++;
      if (o1_v) o1_seen = 1'b1;
      in0_v = (k < 10); in0_p = mk(4'd5, 13'(k), 9'd0, 8'(k));
      in1_v = (k < 10); in1_p = mk(4'd6, 13'(k), 9'd0, 8'(k));
      @(negedge clk);
    end
    check(drops == 4, "R9", "total drops", drops, 4);
    check(outs == 16, "R9", "delivered packets", outs, 16);
    check(!o1_seen, "R2", "output 1 silent under load", o1_seen, 0);
    check(full == 0 && drop == 0 && !o0_v, "R8", "drained", {full, drop, o0_v}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule